// File: doc/BRIEF.md
# Line Violation Interrupt Controller

This block raises the interrupt for one receive channel's line-code violation alarm. For each received bit it gets a valid strobe and a violation flag, and a strobe that marks the last bit of a frame. Within a frame it notes whether any violation arrived. At the frame boundary it compares that per-frame violation state with the state kept from the previous frame. When the two differ, it sets a sticky status bit. The status bit therefore records transitions of the alarm, not each violation.

The interrupt output needs three things at once: the status bit, a per-source enable, and a block-wide enable that governs the whole alarm/error group. A host reads and writes the enables, the status and a control register over a small register port. The port has an 8-bit address, 8-bit data, single-cycle read and write strobes, and read data decoded combinationally from the address. A mode bit in the control register chooses how the status bit is cleared. In one mode a host read clears it. In the other mode the host writes a one to it.

Top module: `bpv_alarm_irq`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Offset 0x01 (block enable register) and offset 0x03 (source enable register) store and read back a full byte. Offset 0x04 (control register) holds only bit 0 and reads 0 elsewhere. Any other offset reads 0x00 and ignores writes.
- R3: At a frame end, the status bit is set if the frame's violation state differs from the previous frame's state. The violation state is 1 when any valid bit of the frame carried a violation, and the state before the first frame is 0. The status bit is bit 3 of offset 0x02 and is visible from the cycle after the frame-end strobe.
- R4: A frame whose violation state equals that of the previous frame leaves the status bit unchanged. The status bit changes only through a state change or a clear.
- R5: With control bit 0 = 1 (read-clear mode), a read strobe at offset 0x02 returns the status and clears it in the next cycle. In this mode, writes to offset 0x02 have no effect.
- R6: With control bit 0 = 0 (write-clear mode), a read does not clear the status. Writing 1 to bit 3 of offset 0x02 clears it, and writing 0 to that bit leaves it set.
- R7: `irq` is high exactly when the status bit, bit 3 of offset 0x03 and bit 1 of offset 0x01 are all 1. Other bits of those registers have no effect on `irq`.
- R8: A state change in the same cycle as a clear, by read or by write, leaves the status bit set.
- R9: `bit_viol` is ignored on cycles where `bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A received bit is present this cycle |
| bit_viol | input | 1 | The present bit carries a line-code violation |
| frame_end | input | 1 | Present cycle is the last of a frame |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| irq | output | 1 | Active-high interrupt |

## Verification
A table of frames mixes clean and violating frames in every pairwise order. This separates state-change detection from plain violation detection, because two violating frames in a row must not set the status. Frames that carry violation flags only on invalid bit slots show whether the valid strobe gates the input. The enable registers are written with patterns that set every bit except the one that matters, which shows that the gating uses the correct bit positions. Clears by read and by write are each placed in the same cycle as a frame end that carries a state change, in both modes, to expose a wrong priority between set and clear.

// File: rtl/bpv_pkg.sv
package bpv_pkg;

    localparam int BPV_AW = 8;
    localparam int BPV_DW = 8;

    // register offsets (host side)
    localparam int OFS_BLK_EN  = 8'h01;
    localparam int OFS_STATUS  = 8'h02;
    localparam int OFS_SRC_EN  = 8'h03;
    localparam int OFS_CONTROL = 8'h04;

    // bit positions inside those registers
    localparam int BIT_BLK_EN = 1;
    localparam int BIT_SRC_EN = 3;
    localparam int BIT_STATUS = 3;
    localparam int BIT_RDCLR  = 0;

    typedef struct packed {
        logic seen;   // a valid violation arrived in the frame so far
        logic state;  // violation state of the last completed frame
    } trk_state_t;

    typedef struct packed {
        logic [BPV_DW-1:0] blk;
        logic [BPV_DW-1:0] src;
        logic              rdclr;
        logic              stat;
    } reg_state_t;

endpackage

// File: rtl/bpv_state_trk.sv
module bpv_state_trk
    import bpv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_viol,
    input  logic frame_end,
    output logic chg_evt
);

    trk_state_t trk_d, trk_q;
    logic       seen_now;

    always_comb begin
        trk_d    = trk_q;
        seen_now = trk_q.seen | (bit_valid & bit_viol);
        chg_evt  = 1'b0;
        if (frame_end) begin
            chg_evt     = (seen_now != trk_q.state);
            trk_d.state = seen_now;
            trk_d.seen  = 1'b0;
        end else begin
            trk_d.seen  = seen_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/bpv_reg_bank.sv
module bpv_reg_bank
    import bpv_pkg::*;
#(
    parameter int AW         = BPV_AW,
    parameter int BLK_OFS    = OFS_BLK_EN,
    parameter int STAT_OFS   = OFS_STATUS,
    parameter int SRC_OFS    = OFS_SRC_EN,
    parameter int CTL_OFS    = OFS_CONTROL,
    parameter int BLK_BIT    = BIT_BLK_EN,
    parameter int SRC_BIT    = BIT_SRC_EN,
    parameter int STAT_BIT   = BIT_STATUS,
    parameter int RDCLR_BIT  = BIT_RDCLR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [BPV_DW-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic              chg_evt,
    output logic [BPV_DW-1:0] rdata,
    output logic              blk_en,
    output logic              src_en,
    output logic              rdclr_mode,
    output logic              stat
);

    localparam int DW = BPV_DW;

    reg_state_t rg_d, rg_q;

    logic hit_blk, hit_stat, hit_src, hit_ctl;
    logic clr_by_rd, clr_by_wr;

    always_comb begin
        hit_blk  = (addr == AW'(BLK_OFS));
        hit_stat = (addr == AW'(STAT_OFS));
        hit_src  = (addr == AW'(SRC_OFS));
        hit_ctl  = (addr == AW'(CTL_OFS));

        clr_by_rd = rg_q.rdclr  & rd & hit_stat;
        clr_by_wr = ~rg_q.rdclr & wr & hit_stat & wdata[STAT_BIT];

        rg_d = rg_q;
        if (wr && hit_blk) rg_d.blk   = wdata;
        if (wr && hit_src) rg_d.src   = wdata;
        if (wr && hit_ctl) rg_d.rdclr = wdata[RDCLR_BIT];

        // a state change outranks any clear in the same cycle
        if (chg_evt)                      rg_d.stat = 1'b1;
        else if (clr_by_rd || clr_by_wr)  rg_d.stat = 1'b0;

        rdata = '0;
        if (hit_blk)       rdata = rg_q.blk;
        else if (hit_src)  rdata = rg_q.src;
        else if (hit_stat) rdata[STAT_BIT]  = rg_q.stat;
        else if (hit_ctl)  rdata[RDCLR_BIT] = rg_q.rdclr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign blk_en     = rg_q.blk[BLK_BIT];
    assign src_en     = rg_q.src[SRC_BIT];
    assign rdclr_mode = rg_q.rdclr;
    assign stat       = rg_q.stat;

endmodule

// File: rtl/bpv_irq_gate.sv
module bpv_irq_gate (
    input  logic stat,
    input  logic src_en,
    input  logic blk_en,
    output logic irq
);

    logic src_req;

    always_comb begin
        src_req = stat & src_en;   // per-source level
        irq     = src_req & blk_en; // group level
    end

endmodule

// File: rtl/bpv_alarm_irq.sv
module bpv_alarm_irq
    import bpv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_viol,
    input  logic              frame_end,
    input  logic [BPV_AW-1:0] host_addr,
    input  logic [BPV_DW-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [BPV_DW-1:0] host_rdata,
    output logic              irq
);

    logic chg_evt;
    logic blk_en, src_en, rdclr_mode, stat;

    bpv_state_trk u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_viol  (bit_viol),
        .frame_end (frame_end),
        .chg_evt   (chg_evt)
    );

    bpv_reg_bank u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .wr         (host_wr),
        .rd         (host_rd),
        .chg_evt    (chg_evt),
        .rdata      (host_rdata),
        .blk_en     (blk_en),
        .src_en     (src_en),
        .rdclr_mode (rdclr_mode),
        .stat       (stat)
    );

    bpv_irq_gate u_gate (
        .stat   (stat),
        .src_en (src_en),
        .blk_en (blk_en),
        .irq    (irq)
    );

endmodule

// File: rtl/bpv_irq_chk.sv
module bpv_irq_chk
    import bpv_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chg_evt,
    input logic              stat,
    input logic              rdclr_mode,
    input logic              blk_en,
    input logic              src_en,
    input logic              irq,
    input logic              host_rd,
    input logic              host_wr,
    input logic [BPV_AW-1:0] host_addr,
    input logic [BPV_DW-1:0] host_wdata
);

    logic at_stat;
    assign at_stat = (host_addr == BPV_AW'(OFS_STATUS));

    a_r3_change_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        chg_evt |=> stat);

    a_r4_status_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_evt && !host_rd && !host_wr) |=> $stable(stat));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rdclr_mode && host_rd && at_stat && !chg_evt) |=> !stat);

    a_r6_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdclr_mode && host_wr && at_stat && !host_wdata[BIT_STATUS] && stat) |=> stat);

    a_r7_irq_needs_all_three: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat || !src_en || !blk_en) |-> !irq);

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_evt && at_stat && (host_rd || host_wr)) |=> stat);

endmodule

bind bpv_alarm_irq bpv_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chg_evt    (chg_evt),
    .stat       (stat),
    .rdclr_mode (rdclr_mode),
    .blk_en     (blk_en),
    .src_en     (src_en),
    .irq        (irq),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata)
);

// File: tb/tb_bpv_alarm_irq.sv
module tb_bpv_alarm_irq;

    localparam int FB = 8;      // bit slots per frame in this bench
    localparam int NV = 8;

    // {violating frame, expected status after it}, starting from state 0
    localparam logic [1:0] VEC [NV] = '{
        2'b00, 2'b11, 2'b10, 2'b01, 2'b00, 2'b11, 2'b01, 2'b11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0, bit_viol = 1'b0, frame_end = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    bpv_alarm_irq dut (
        .clk(clk), .rst_n(rst_n),
        .bit_valid(bit_valid), .bit_viol(bit_viol), .frame_end(frame_end),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b0;
        #1 d = host_rdata;
    endtask

    // act: 0 none, 1 clear-write on last slot, 2 status read on last slot
    task automatic frame(input logic viol, input int act, input logic masked);
        for (int i = 0; i < FB; i++) begin
            bit_valid = !masked || (i == FB-1);
            bit_viol  = masked ? (i != FB-1) : (viol && i == 3);
            frame_end = (i == FB-1);
            if (i == FB-1 && act == 1) begin
                host_addr = 8'h02; host_wdata = 8'h08; host_wr = 1'b1;
            end
            if (i == FB-1 && act == 2) begin
                host_addr = 8'h02; host_rd = 1'b1;
            end
            tick();
            host_wr = 1'b0; host_rd = 1'b0;
        end
        bit_valid = 1'b0; bit_viol = 1'b0; frame_end = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        peek(8'h01, v); chk("R1 blk", v, 8'h00);
        peek(8'h02, v); chk("R1 stat", v, 8'h00);
        peek(8'h03, v); chk("R1 src", v, 8'h00);
        peek(8'h04, v); chk("R1 ctl", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();

        // R2 register access
        wr(8'h01, 8'hA5); peek(8'h01, v); chk("R2 blk rw", v, 8'hA5);
        wr(8'h03, 8'h5A); peek(8'h03, v); chk("R2 src rw", v, 8'h5A);
        wr(8'h04, 8'hFF); peek(8'h04, v); chk("R2 ctl bit0 only", v, 8'h01);
        wr(8'h07, 8'h33); peek(8'h07, v); chk("R2 unmapped", v, 8'h00);
        wr(8'h01, 8'h02); wr(8'h03, 8'h08); wr(8'h04, 8'h00);

        // R3/R4/R6 table of frames, write-clear mode
        for (int k = 0; k < NV; k++) begin
            frame(VEC[k][1], 0, 1'b0);
            peek(8'h02, v); chk("R3/R4 status", v, {4'b0, VEC[k][0], 3'b0});
            chk("R7 irq follows status", {7'b0, irq}, {7'b0, VEC[k][0]});
            if (VEC[k][0]) begin
                rd(8'h02, v); peek(8'h02, v); chk("R6 read keeps", v, 8'h08);
                wr(8'h02, 8'h00); peek(8'h02, v); chk("R6 zero write keeps", v, 8'h08);
                wr(8'h02, 8'h08); peek(8'h02, v); chk("R6 one write clears", v, 8'h00);
            end
        end

        // R7 gating (state now 1; clean frame makes a change)
        frame(1'b0, 0, 1'b0);
        chk("R7 both on", {7'b0, irq}, 8'h01);
        wr(8'h01, 8'hFD); chk("R7 blk off", {7'b0, irq}, 8'h00);
        wr(8'h01, 8'h02); wr(8'h03, 8'hF7); chk("R7 src off", {7'b0, irq}, 8'h00);
        wr(8'h03, 8'h08); chk("R7 restored", {7'b0, irq}, 8'h01);
        wr(8'h02, 8'h08);
        chk("R7 cleared", {7'b0, irq}, 8'h00);

        // R9 violations on invalid slots only (state stays 0)
        frame(1'b0, 0, 1'b1);
        peek(8'h02, v); chk("R9 invalid ignored", v, 8'h00);

        // R5 read-clear mode
        wr(8'h04, 8'h01);
        frame(1'b1, 0, 1'b0);
        peek(8'h02, v); chk("R5 set", v, 8'h08);
        wr(8'h02, 8'h08); peek(8'h02, v); chk("R5 write ignored", v, 8'h08);
        rd(8'h02, v); chk("R5 read value", v, 8'h08);
        peek(8'h02, v); chk("R5 cleared by read", v, 8'h00);
        chk("R5 irq low", {7'b0, irq}, 8'h00);

        // R8 set wins over clear-by-read
        frame(1'b1, 0, 1'b0);
        peek(8'h02, v); chk("R4 same state", v, 8'h00);
        frame(1'b0, 2, 1'b0);
        peek(8'h02, v); chk("R8 read vs set", v, 8'h08);

        // R8 set wins over clear-by-write
        wr(8'h04, 8'h00);
        frame(1'b1, 1, 1'b0);
        peek(8'h02, v); chk("R8 write vs set", v, 8'h08);
        wr(8'h02, 8'h08); peek(8'h02, v); chk("R6 final clear", v, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule